// File: doc/BRIEF.md
# SD Card Clock Divider with Data Timeout

This block produces the card-side clock for an SD host from the controller's base clock. It also watches data transfers and flags those that stall. Software writes one 32-bit control word. The word holds:

- an internal clock enable, with a read-only stable flag;
- a one-hot divider select byte;
- a separate gate for the card clock;
- a 4-bit timeout exponent;
- three self-clearing soft-reset requests: whole block, command line and data line.

The card clock comes out in two forms. `sdclk` is a level. `sdclk_rise` is a one-cycle strobe that marks each card clock rising edge, and downstream logic uses it as a clock enable. A new divider or a closed gate takes effect only at the end of the current card clock period, so no period is ever cut short. The transfer engine reports through `xfer_active` and `data_act`, and a timebase strobe `tm_tick` drives the timeout counter. If no activity pulse arrives within 2^(TO_OFFSET+n) ticks, the block sets a sticky data-timeout error.

Top module: `sdclk_timeout_ctrl`

## Requirements
- R1: Divider byte (control bits 15:8) 0x00 gives a card clock period of 1 base cycle. A byte with only bit i set gives a period of 2^(i+1) cycles, so 0x01 gives 2 and 0x80 gives 256. `sdclk_rise` pulses once per period. `sdclk` is high for the first half of each period, or constantly high at divide by 1.
- R2: A non-zero divider byte with more than one bit set divides by 256.
- R3: A divider change written in the middle of a period leaves that period at the old length. The next period uses the new value.
- R4: The clock-stable flag (control bit 1, read-only) reads 1 from the 4th clock edge after the edge that writes internal enable (bit 0) to 1. It reads 0 right after the edge that writes the enable to 0.
- R5: The card clock runs only while the gate (bit 2) is set and the clock is stable. Otherwise `sdclk` and `sdclk_rise` stay low. After the gate is set with the clock stable, the first rising strobe appears one edge after the write edge.
- R6: Writing 1 to a reset request (bit 24 all, bit 25 command line, bit 26 data line) makes that bit read 1, and drives its `srst_*` output high, for exactly one cycle after the write.
- R7: A write with bit 24 set clears the enable, gate, divider and timeout fields, whatever the other data bits hold.
- R8: With `xfer_active` high and `tm_tick` high on every edge, `dto_err` rises on the 2^(TO_OFFSET+n)-th edge, where n is control bits 19:16. Code 15 behaves as code 14.
- R9: A `data_act` pulse restarts the count from zero. No counting happens while `xfer_active` is low or `tm_tick` is low.
- R10: `dto_err` stays set until a data-line or all reset request. The error clears on the edge after the request's write edge.
- R11: After reset, `cfg_rdata` is 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word readback with stable flag and reset requests |
| xfer_active | input | 1 | A data transfer is in progress |
| data_act | input | 1 | Pulse on each data-line activity from the card |
| tm_tick | input | 1 | Timeout timebase strobe |
| sdclk | output | 1 | Card clock level |
| sdclk_rise | output | 1 | One-cycle strobe at each card clock rising edge |
| dto_err | output | 1 | Sticky data timeout error |
| srst_all | output | 1 | One-cycle whole-block reset request |
| srst_cmd | output | 1 | One-cycle command-line reset request |
| srst_dat | output | 1 | One-cycle data-line reset request |

## Verification
The divider is swept through divide by 1 and every one-hot code. This separates an off-by-one in the exponent decode from a wrong half-period level, because both the period length and the high-time count are checked. Two malformed bytes, 0x03 and 0xFF, confirm the fallback to 256. A rewrite in the middle of a long period shows whether the new divisor is wrongly applied before the period ends. The timeout runs with codes 0, 3 and the reserved 15, with an activity pulse part way through, with the timebase held low and with the transfer idle. Together these tell the interval exponent apart from the restart, gating and clamp behaviour.

// File: rtl/sdtm_pkg.sv
package sdtm_pkg;
    localparam int REG_W      = 32;
    localparam int DIV_W      = 8;
    localparam int TO_W       = 4;
    localparam int B_INT_EN   = 0;
    localparam int B_STABLE   = 1;
    localparam int B_GATE     = 2;
    localparam int B_DIV_LO   = 8;
    localparam int B_TO_LO    = 16;
    localparam int B_RST_ALL  = 24;
    localparam int B_RST_CMD  = 25;
    localparam int B_RST_DAT  = 26;

    typedef struct packed {
        logic              int_en;
        logic              gate;
        logic [DIV_W-1:0]  div_sel;
        logic [TO_W-1:0]   to_code;
    } ctrl_t;

    typedef struct packed {
        logic all;
        logic cmd;
        logic dat;
    } srst_t;
endpackage

// File: rtl/sdtm_ctrl_regs.sv
module sdtm_ctrl_regs
    import sdtm_pkg::*;
#(
    parameter int STABLE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic             stable,
    output srst_t            srst
);
    localparam int SW = $clog2(STABLE_CYCLES + 1);

    typedef struct packed {
        ctrl_t          ctrl;
        srst_t          srst;
        logic [SW-1:0]  scnt;
        logic           stable;
    } state_t;

    state_t d, q;

    logic unused_bits;
    assign unused_bits = ^{wdata[31:27], wdata[23:20], wdata[7:3], wdata[B_STABLE]};

    always_comb begin
        d      = q;
        d.srst = '0;
        if (we) begin
            d.srst.all = wdata[B_RST_ALL];
            d.srst.cmd = wdata[B_RST_CMD];
            d.srst.dat = wdata[B_RST_DAT];
            if (wdata[B_RST_ALL]) begin
                d.ctrl = '0;
            end else begin
                d.ctrl.int_en  = wdata[B_INT_EN];
                d.ctrl.gate    = wdata[B_GATE];
                d.ctrl.div_sel = wdata[B_DIV_LO +: DIV_W];
                d.ctrl.to_code = wdata[B_TO_LO +: TO_W];
            end
        end
        // stable counter follows the next enable so a clear drops the flag at once
        if (!d.ctrl.int_en) begin
            d.scnt   = '0;
            d.stable = 1'b0;
        end else if (q.scnt == SW'(STABLE_CYCLES)) begin
            d.stable = 1'b1;
        end else begin
            d.scnt = q.scnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl   = q.ctrl;
    assign stable = q.stable;
    assign srst   = q.srst;

    p_stable_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.stable |-> q.ctrl.int_en);
    p_stable_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.stable) |-> $past(q.ctrl.int_en));
    p_srst_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|q.srst) |-> $past(we));
    p_all_clears_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.srst.all |-> (q.ctrl == '0));
endmodule

// File: rtl/sdtm_clkdiv.sv
module sdtm_clkdiv #(
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             gate_en,
    input  logic             clk_stable,
    output logic             sdclk,
    output logic             sdclk_rise
);
    localparam int EXP_W  = $clog2(SEL_W + 1);
    localparam int SPAN_W = SEL_W + 1;

    typedef struct packed {
        logic [EXP_W-1:0] exp;
        logic [SEL_W-1:0] cnt;
        logic             run;
    } state_t;

    state_t d, q;
    logic [SPAN_W-1:0] span;
    logic              last;
    logic [EXP_W-1:0]  new_exp;

    function automatic logic [EXP_W-1:0] sel_to_exp(input logic [SEL_W-1:0] s);
        logic [EXP_W-1:0] e;
        e = EXP_W'(SEL_W);
        if (s == '0) begin
            e = '0;
        end else if ((s & (s - 1'b1)) == '0) begin
            for (int i = 0; i < SEL_W; i++) begin
                if (s[i]) e = EXP_W'(i + 1);
            end
        end
        return e;
    endfunction

    always_comb begin
        new_exp = sel_to_exp(div_sel);
        span    = SPAN_W'(1) << q.exp;
        last    = (q.cnt == (span[SEL_W-1:0] - 1'b1));
        d       = q;
        if (!clk_stable) begin
            d.run = 1'b0;
            d.cnt = '0;
        end else if (!q.run || last) begin
            // period boundary: only here may divisor or gate change
            d.cnt = '0;
            d.exp = new_exp;
            d.run = gate_en;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdclk_rise = q.run && (q.cnt == '0);
    assign sdclk      = q.run && ((q.exp == '0) || ({1'b0, q.cnt} < (span >> 1)));

    p_div_change_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.exp) |-> $past(!q.run || last));
    p_run_needs_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_stable |=> !q.run);
    p_rise_only_when_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sdclk_rise |-> sdclk);
endmodule

// File: rtl/sdtm_timeout.sv
module sdtm_timeout #(
    parameter int OFFSET = 13,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] to_code,
    input  logic              xfer_active,
    input  logic              data_act,
    input  logic              tick,
    input  logic              clear,
    output logic              err
);
    localparam int MAX_CODE = (1 << CODE_W) - 2;
    localparam int TW       = OFFSET + MAX_CODE + 1;

    typedef struct packed {
        logic [TW-1:0] timer;
        logic          err;
    } state_t;

    state_t d, q;
    logic [CODE_W-1:0] code_eff;
    logic [TW-1:0]     limit_m1;

    always_comb begin
        code_eff = (to_code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : to_code;
        limit_m1 = (TW'(1) << (OFFSET + int'(code_eff))) - 1'b1;
        d = q;
        if (clear) begin
            d.timer = '0;
            d.err   = 1'b0;
        end else if (!xfer_active || data_act) begin
            d.timer = '0;
        end else if (tick) begin
            if (q.timer >= limit_m1) begin
                d.timer = '0;
                d.err   = 1'b1;
            end else begin
                d.timer = q.timer + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign err = q.err;

    p_idle_holds_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> (q.timer == '0));
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !clear) |=> q.err);
    p_err_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> $past(xfer_active && tick && !data_act));
endmodule

// File: rtl/sdclk_timeout_ctrl.sv
module sdclk_timeout_ctrl
    import sdtm_pkg::*;
#(
    parameter int STABLE_CYCLES = 4,
    parameter int TO_OFFSET     = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        xfer_active,
    input  logic        data_act,
    input  logic        tm_tick,
    output logic        sdclk,
    output logic        sdclk_rise,
    output logic        dto_err,
    output logic        srst_all,
    output logic        srst_cmd,
    output logic        srst_dat
);
    ctrl_t ctrl;
    srst_t srst;
    logic  stable;

    sdtm_ctrl_regs #(.STABLE_CYCLES(STABLE_CYCLES)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .ctrl   (ctrl),
        .stable (stable),
        .srst   (srst)
    );

    sdtm_clkdiv #(.SEL_W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_sel    (ctrl.div_sel),
        .gate_en    (ctrl.gate),
        .clk_stable (stable),
        .sdclk      (sdclk),
        .sdclk_rise (sdclk_rise)
    );

    sdtm_timeout #(.OFFSET(TO_OFFSET), .CODE_W(TO_W)) u_to (
        .clk         (clk),
        .rst_n       (rst_n),
        .to_code     (ctrl.to_code),
        .xfer_active (xfer_active),
        .data_act    (data_act),
        .tick        (tm_tick),
        .clear       (srst.all | srst.dat),
        .err         (dto_err)
    );

    assign cfg_rdata = {5'b0, srst.dat, srst.cmd, srst.all, 4'b0, ctrl.to_code,
                        ctrl.div_sel, 5'b0, ctrl.gate, stable, ctrl.int_en};
    assign srst_all  = srst.all;
    assign srst_cmd  = srst.cmd;
    assign srst_dat  = srst.dat;
endmodule

// File: tb/tb_sdclk_timeout_ctrl.sv
module tb_sdclk_timeout_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        xfer_active = 1'b0;
    logic        data_act = 1'b0;
    logic        tm_tick = 1'b1;
    logic        sdclk, sdclk_rise, dto_err, srst_all, srst_cmd, srst_dat;

    localparam int OFS = 2;

    sdclk_timeout_ctrl #(.STABLE_CYCLES(4), .TO_OFFSET(OFS)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .xfer_active(xfer_active), .data_act(data_act),
        .tm_tick(tm_tick), .sdclk(sdclk), .sdclk_rise(sdclk_rise),
        .dto_err(dto_err), .srst_all(srst_all), .srst_cmd(srst_cmd),
        .srst_dat(srst_dat)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    per;
        string req;
    } item_t;

    item_t sb[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    arm     = 1'b0;
    bit    done    = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [31:0] mk(input bit en, input bit gate, input logic [7:0] dv,
                                       input logic [3:0] to);
        return {12'b0, to, dv, 5'b0, gate, 1'b0, en};
    endfunction

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // monitor: measures period and high time between rising strobes
    longint cyc = 0, last = 0;
    int     hi = 0;
    bit     have_last = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (!arm) begin
            have_last = 1'b0;
            hi = 0;
        end else if (sdclk_rise) begin
            if (have_last && sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk((cyc - last) == it.per, it.req, cyc - last, it.per);
                chk(hi == ((it.per == 1) ? 1 : it.per / 2), it.req, hi,
                    (it.per == 1) ? 1 : it.per / 2);
            end
            have_last = 1'b1;
            last = cyc;
            hi = sdclk ? 1 : 0;
        end else begin
            hi += sdclk ? 1 : 0;
        end
    end

    task automatic run_div(input logic [7:0] code, input int per, input int n, input string req);
        wr(mk(1, 1, code, 0));
        repeat (600) @(negedge clk);
        arm = 1'b1;
        for (int k = 0; k < n; k++) sb.push_back('{per, req});
        while (sb.size() > 0) @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic clear_err();
        xfer_active = 1'b0;
        wr(mk(1, 0, 0, 0) | 32'h0400_0000);
        @(negedge clk);
    endtask

    task automatic to_run(input logic [3:0] code, input int len, input string req);
        wr(mk(1, 0, 0, code));
        clear_err();
        wr(mk(1, 0, 0, code));
        chk(dto_err == 1'b0, req, dto_err, 0);
        xfer_active = 1'b1;
        repeat (len - 1) @(negedge clk);
        chk(dto_err == 1'b0, req, dto_err, 0);
        @(negedge clk);
        chk(dto_err == 1'b1, req, dto_err, 1);
        xfer_active = 1'b0;
    endtask

    task automatic finish_tb();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_tb();
    end

    initial begin
        int rises;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(cfg_rdata == 32'h0, "R11", cfg_rdata, 0);
        chk({sdclk, sdclk_rise, dto_err, srst_all, srst_cmd, srst_dat} == 6'b0, "R11",
            {sdclk, sdclk_rise, dto_err, srst_all, srst_cmd, srst_dat}, 0);

        // R4 stable timing
        wr(mk(1, 0, 8'h01, 0));
        chk(cfg_rdata[1] == 1'b0, "R4", cfg_rdata[1], 0);
        repeat (3) @(negedge clk);
        chk(cfg_rdata[1] == 1'b0, "R4", cfg_rdata[1], 0);
        @(negedge clk);
        chk(cfg_rdata[1] == 1'b1, "R4", cfg_rdata[1], 1);
        wr(mk(0, 0, 8'h01, 0));
        chk(cfg_rdata[1] == 1'b0, "R4", cfg_rdata[1], 0);

        // R5 no clock without gate, or with gate but not stable
        wr(mk(1, 0, 8'h01, 0));
        rises = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            rises += (sdclk_rise || sdclk) ? 1 : 0;
        end
        chk(rises == 0, "R5", rises, 0);
        wr(mk(0, 1, 8'h01, 0));
        rises = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            rises += (sdclk_rise || sdclk) ? 1 : 0;
        end
        chk(rises == 0, "R5", rises, 0);
        wr(mk(1, 0, 8'h01, 0));
        repeat (6) @(negedge clk);
        wr(mk(1, 1, 8'h01, 0));
        chk(sdclk_rise == 1'b0, "R5", sdclk_rise, 0);
        @(negedge clk);
        chk(sdclk_rise == 1'b1, "R5", sdclk_rise, 1);

        // R1 divide by 1 and every one-hot code
        run_div(8'h00, 1, 3, "R1");
        for (int i = 0; i < 8; i++) run_div(8'(1 << i), 2 << i, 3, "R1");

        // R2 malformed codes
        run_div(8'h03, 256, 2, "R2");
        run_div(8'hFF, 256, 2, "R2");

        // R3 mid-period change
        wr(mk(1, 1, 8'h80, 0));
        repeat (600) @(negedge clk);
        arm = 1'b1;
        sb.push_back('{256, "R3"});
        sb.push_back('{256, "R3"});
        sb.push_back('{2, "R3"});
        sb.push_back('{2, "R3"});
        sb.push_back('{2, "R3"});
        while (sb.size() > 4) @(negedge clk);
        repeat (5) @(negedge clk);
        wr(mk(1, 1, 8'h01, 0));
        while (sb.size() > 0) @(negedge clk);
        arm = 1'b0;

        // R6 self-clearing reset requests
        wr(mk(1, 0, 0, 0) | 32'h0200_0000);
        chk(cfg_rdata[25] == 1'b1 && srst_cmd && !srst_all && !srst_dat, "R6",
            cfg_rdata[26:24], 3'b010);
        @(negedge clk);
        chk(cfg_rdata[26:24] == 3'b000 && !srst_cmd, "R6", cfg_rdata[26:24], 0);
        wr(mk(1, 0, 0, 0) | 32'h0400_0000);
        chk(srst_dat && cfg_rdata[26], "R6", srst_dat, 1);
        @(negedge clk);
        chk(!srst_dat, "R6", srst_dat, 0);

        // R8 intervals, including reserved code
        to_run(4'd0, 1 << OFS, "R8");
        to_run(4'd3, 1 << (OFS + 3), "R8");

        // R10 sticky then cleared by data-line reset
        repeat (10) @(negedge clk);
        chk(dto_err == 1'b1, "R10", dto_err, 1);
        wr(mk(1, 0, 0, 4'd3) | 32'h0400_0000);
        chk(dto_err == 1'b1, "R10", dto_err, 1);
        @(negedge clk);
        chk(dto_err == 1'b0, "R10", dto_err, 0);

        // R9 activity restart
        wr(mk(1, 0, 0, 4'd3));
        xfer_active = 1'b1;
        repeat (20) @(negedge clk);
        data_act = 1'b1;
        @(negedge clk);
        data_act = 1'b0;
        repeat ((1 << (OFS + 3)) - 1) @(negedge clk);
        chk(dto_err == 1'b0, "R9", dto_err, 0);
        @(negedge clk);
        chk(dto_err == 1'b1, "R9", dto_err, 1);

        // R9 idle and tick low do not count
        clear_err();
        wr(mk(1, 0, 0, 4'd0));
        repeat (100) @(negedge clk);
        chk(dto_err == 1'b0, "R9", dto_err, 0);
        tm_tick = 1'b0;
        xfer_active = 1'b1;
        repeat (50) @(negedge clk);
        chk(dto_err == 1'b0, "R9", dto_err, 0);
        tm_tick = 1'b1;
        xfer_active = 1'b0;

        // R7 reset-all clears fields and error
        to_run(4'd0, 1 << OFS, "R7");
        wr(32'h0100_FF05 | 32'h0003_0000);
        chk(cfg_rdata == 32'h0100_0000, "R7", cfg_rdata, 32'h0100_0000);
        @(negedge clk);
        chk(cfg_rdata == 32'h0 && dto_err == 1'b0, "R7", cfg_rdata, 0);

        // R8 reserved code behaves as 14
        wr(mk(1, 0, 0, 0));
        to_run(4'd15, 1 << (OFS + 14), "R8");

        finish_tb();
    end
endmodule